// File: doc/BRIEF.md
# Token-Aware Store Queue Matcher

This block is a small in-order store queue that sits between a core's load/store pipeline and the data cache in a design that supports poisoned memory lines. The core can enqueue three kinds of operations: ordinary stores, "arm" commands that turn a 64-byte line into a trap line, and "disarm" commands that turn such a line back into ordinary memory. Arm and disarm entries keep only a one-bit token marker (encoded in the kind field) and the line address. They carry no line-wide data.

One load-lookup port checks each incoming load against every pending entry. The youngest pending entry that overlaps the load decides the result. If it is an arm, the load is a token violation. If it is a disarm, or a regular store that covers only part of the load, the load stalls. If it is a regular store that fully covers the load, its bytes are forwarded. Regular stores use byte-precise overlap. Token entries use line-granular overlap, so an unaligned access that straddles two lines is compared against both of them. An incoming regular store is checked the same way against pending token entries. If it hits an armed line it is reported and dropped. Entries leave for the cache in program order. An arm or disarm leaves as one line-wide command.

Top module: `tkq_top`

## Requirements
- R1: After reset the queue is empty: `dc_valid` is 0, `enq_ready` is 1, and `ld_fwd`, `ld_stall`, `ld_viol` and `st_viol` are 0 while no request is presented.
- R2: Entries are presented on the cache port in the order they were accepted, one per `dc_valid && dc_ready` cycle, and the presented entry holds while `dc_ready` is low. Kind encoding is 0 = regular store, 1 = arm, 2 = disarm. A regular entry is presented with its own address, size and data. A token entry is presented with its line address (bits 5:0 zero), size 0 and data 0.
- R3: The queue holds 8 entries. With 8 entries pending, `enq_ready` is 0 and an offered entry is not taken.
- R4: An access covers bytes `addr` to `addr + (1 << size) - 1`, with size codes 0..3 meaning 1, 2, 4 or 8 bytes. If the youngest pending entry overlapping a load is a regular store whose bytes contain all of the load's bytes, `ld_fwd` is 1. `ld_data` then holds the load's bytes taken from that store's data (store byte k at data bits 8k+7:8k), starting in the low byte, with the bits above the load size zero.
- R5: If the youngest overlapping entry is a regular store that covers the load only partly, `ld_stall` is 1 and nothing is forwarded.
- R6: A disarm entry never supplies data. If it is the youngest entry whose line a load touches, the load stalls.
- R7: If the youngest entry overlapping a load is an arm whose line the load touches, `ld_viol` is 1. `ld_viol_idx` gives that entry's slot and `ld_viol_line` gives address bits 31:6 of its line. Slots are numbered 0..7. After reset the first accepted entry takes slot 0, and each further entry takes the next slot, wrapping from 7 to 0.
- R8: An access whose bytes straddle two 64-byte lines is checked against the token entries of both lines.
- R9: A regular store offered while the youngest pending token entry for any line it touches is an arm raises `st_viol`, with that slot on `st_viol_idx` and its line on `st_viol_line`. The store is not enqueued.
- R10: A disarm that is younger than an arm for the same line cancels the violation, both for later loads and for later stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Core offers an entry |
| enq_ready | output | 1 | Queue has room |
| enq_kind | input | 2 | 0 store, 1 arm, 2 disarm |
| enq_addr | input | 32 | Byte address |
| enq_size | input | 2 | log2 of store bytes |
| enq_data | input | 64 | Store data, low-byte aligned |
| st_viol | output | 1 | Offered store hits an armed line |
| st_viol_idx | output | 3 | Slot of the offending arm |
| st_viol_line | output | 26 | Line address of that arm |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address |
| ld_size | input | 2 | log2 of load bytes |
| ld_fwd | output | 1 | Data forwarded |
| ld_data | output | 64 | Forwarded bytes |
| ld_stall | output | 1 | Load must wait |
| ld_viol | output | 1 | Load touches an armed line |
| ld_viol_idx | output | 3 | Slot of the offending arm |
| ld_viol_line | output | 26 | Line address of that arm |
| dc_valid | output | 1 | Oldest entry offered to cache |
| dc_ready | input | 1 | Cache accepts the entry |
| dc_kind | output | 2 | Kind of the offered entry |
| dc_addr | output | 32 | Address (line-aligned for tokens) |
| dc_size | output | 2 | Size code (0 for tokens) |
| dc_data | output | 64 | Data (0 for tokens) |

## Verification
The assertions assume that a lookup compares only against entries accepted in earlier cycles. They also assume that `dc_ready` is a plain accept, not a promise, and that sizes never go beyond the data width. The bench keeps to these conditions. It presents a load in its own cycle after the enqueues it depends on. It raises `dc_ready` only during drain phases, and it uses size codes 0 to 3 only. Address sweeps step byte by byte over every size across regions that contain regular stores, an arm and then a disarm. This covers aligned, partial, spanning and disjoint cases near line edges, and each outcome is computed from an independent model of the queue contents.

// File: rtl/tkq_pkg.sv
package tkq_pkg;

  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_ARM    = 2'd1,
    K_DISARM = 2'd2
  } kind_e;

endpackage

// File: rtl/tkq_ring.sv
module tkq_ring
  import tkq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_kind,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [1:0]                     wr_size,
  input  logic [DW-1:0]                  wr_data,
  input  logic                           rd_en,
  output logic [CW-1:0]                  count_o,
  output logic [PW-1:0]                  head_o,
  output logic [DEPTH-1:0][1:0]          kinds_o,
  output logic [DEPTH-1:0][AW-1:0]       addrs_o,
  output logic [DEPTH-1:0][1:0]          sizes_o,
  output logic [DEPTH-1:0][DW-1:0]       datas_o
);

  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (rd_en) head_d = step(head_q);
    if (wr_en) tail_d = step(tail_q);
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // Payload slots: no reset, written only under their own enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          slot_we;
    logic          data_we;
    logic [1:0]    kind_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    size_q;
    logic [DW-1:0] data_q;

    assign slot_we = wr_en && (tail_q == PW'(i));
    // Token entries keep no data: the data field is clock-gated for them.
    assign data_we = slot_we && (wr_kind == K_REG);

    always_ff @(posedge clk) begin
      if (slot_we) begin
        kind_q <= wr_kind;
        addr_q <= wr_addr;
        size_q <= wr_size;
      end
      if (data_we) data_q <= wr_data;
    end

    assign kinds_o[i] = kind_q;
    assign addrs_o[i] = addr_q;
    assign sizes_o[i] = size_q;
    assign datas_o[i] = data_q;
  end

  assign count_o = cnt_q;
  assign head_o  = head_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < CW'(DEPTH))); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/tkq_cmp.sv
module tkq_cmp
  import tkq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int LINE_LSB = 6,
  localparam int XW      = AW + 1,
  localparam int OW      = $clog2(DW / 8)
) (
  input  logic [1:0]    e_kind,
  input  logic [AW-1:0] e_addr,
  input  logic [1:0]    e_size,
  input  logic [AW-1:0] q_addr,
  input  logic [1:0]    q_size,
  output logic          hit,
  output logic          covers,
  output logic [OW-1:0] off
);

  logic [XW-1:0] q_lo, q_hi, q_last;
  logic [XW-1:0] e_lo, e_hi;
  logic          line_hit, byte_hit;

  always_comb begin
    q_lo   = {1'b0, q_addr};
    q_hi   = q_lo + (XW'(1) << q_size);
    q_last = q_hi - XW'(1);
    e_lo   = {1'b0, e_addr};
    e_hi   = e_lo + (XW'(1) << e_size);
    // Line-granular match: both the first and the last line of the access.
    line_hit = (e_lo[XW-1:LINE_LSB] == q_lo[XW-1:LINE_LSB]) ||
               (e_lo[XW-1:LINE_LSB] == q_last[XW-1:LINE_LSB]);
    // Byte-precise match for regular stores.
    byte_hit = (e_lo < q_hi) && (q_lo < e_hi);
    covers   = (e_lo <= q_lo) && (q_hi <= e_hi);
    off      = q_addr[OW-1:0] - e_addr[OW-1:0];
    hit      = (e_kind == K_REG) ? byte_hit : line_hit;
  end

endmodule

// File: rtl/tkq_pick.sv
module tkq_pick #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [PW-1:0]    head,
  input  logic [CW-1:0]    count,
  input  logic [DEPTH-1:0] hits,
  output logic             any,
  output logic [PW-1:0]    idx
);

  logic [PW:0] slot;

  // Walk from oldest to youngest; the last live hit wins.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    slot = '0;
    for (int a = 0; a < DEPTH; a++) begin
      slot = {1'b0, head} + (PW + 1)'(a);
      if (slot >= (PW + 1)'(DEPTH)) slot = slot - (PW + 1)'(DEPTH);
      if ((CW'(a) < count) && hits[slot[PW-1:0]]) begin
        any = 1'b1;
        idx = slot[PW-1:0];
      end
    end
  end

endmodule

// File: rtl/tkq_top.sv
module tkq_top
  import tkq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int LINE_LSB = 6,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int LW      = AW - LINE_LSB,
  localparam int DB      = DW / 8,
  localparam int OW      = $clog2(DB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [1:0]    enq_kind,
  input  logic [AW-1:0] enq_addr,
  input  logic [1:0]    enq_size,
  input  logic [DW-1:0] enq_data,
  output logic          st_viol,
  output logic [PW-1:0] st_viol_idx,
  output logic [LW-1:0] st_viol_line,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  output logic          ld_fwd,
  output logic [DW-1:0] ld_data,
  output logic          ld_stall,
  output logic          ld_viol,
  output logic [PW-1:0] ld_viol_idx,
  output logic [LW-1:0] ld_viol_line,
  output logic          dc_valid,
  input  logic          dc_ready,
  output logic [1:0]    dc_kind,
  output logic [AW-1:0] dc_addr,
  output logic [1:0]    dc_size,
  output logic [DW-1:0] dc_data
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // Storage
  logic                     wr_en, rd_en;
  logic [AW-1:0]            wr_addr;
  logic [CW-1:0]            count;
  logic [PW-1:0]            head;
  logic [DEPTH-1:0][1:0]    kinds;
  logic [DEPTH-1:0][AW-1:0] addrs;
  logic [DEPTH-1:0][1:0]    sizes;
  logic [DEPTH-1:0][DW-1:0] datas;

  tkq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_kind (enq_kind),
    .wr_addr (wr_addr),
    .wr_size (enq_size),
    .wr_data (enq_data),
    .rd_en   (rd_en),
    .count_o (count),
    .head_o  (head),
    .kinds_o (kinds),
    .addrs_o (addrs),
    .sizes_o (sizes),
    .datas_o (datas)
  );

  // Per-entry comparators, one set for the load port, one for incoming stores
  logic [DEPTH-1:0]         ld_hit, ld_cov, st_hit, st_cov, st_tok;
  logic [DEPTH-1:0][OW-1:0] ld_off, st_off;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    tkq_cmp #(.AW(AW), .DW(DW), .LINE_LSB(LINE_LSB)) u_ld_cmp (
      .e_kind (kinds[i]),
      .e_addr (addrs[i]),
      .e_size (sizes[i]),
      .q_addr (ld_addr),
      .q_size (ld_size),
      .hit    (ld_hit[i]),
      .covers (ld_cov[i]),
      .off    (ld_off[i])
    );
    tkq_cmp #(.AW(AW), .DW(DW), .LINE_LSB(LINE_LSB)) u_st_cmp (
      .e_kind (kinds[i]),
      .e_addr (addrs[i]),
      .e_size (sizes[i]),
      .q_addr (enq_addr),
      .q_size (enq_size),
      .hit    (st_hit[i]),
      .covers (st_cov[i]),
      .off    (st_off[i])
    );
    // Stores only care about token entries.
    assign st_tok[i] = st_hit[i] && (kinds[i] != K_REG);
  end

  logic          ld_any, st_any;
  logic [PW-1:0] ld_idx, st_idx;

  tkq_pick #(.DEPTH(DEPTH)) u_ld_pick (
    .head  (head),
    .count (count),
    .hits  (ld_hit),
    .any   (ld_any),
    .idx   (ld_idx)
  );

  tkq_pick #(.DEPTH(DEPTH)) u_st_pick (
    .head  (head),
    .count (count),
    .hits  (st_tok),
    .any   (st_any),
    .idx   (st_idx)
  );

  // Enqueue side
  logic st_is_reg;
  logic st_arm_hit;
  logic enq_tok;

  always_comb begin
    st_is_reg    = (enq_kind == K_REG);
    enq_tok      = !st_is_reg;
    st_arm_hit   = st_any && (kinds[st_idx] == K_ARM);
    enq_ready    = (count < CW'(DEPTH));
    st_viol      = enq_valid && st_is_reg && st_arm_hit;
    st_viol_idx  = st_viol ? st_idx : '0;
    st_viol_line = st_viol ? addrs[st_idx][AW-1:LINE_LSB] : '0;
    wr_en        = enq_valid && enq_ready && !st_viol;
    wr_addr      = enq_tok ? {enq_addr[AW-1:LINE_LSB], {LINE_LSB{1'b0}}} : enq_addr;
  end

  // Load side: the youngest overlapping entry decides.
  logic [1:0]    sel_kind;
  logic          sel_cov;
  logic [DW-1:0] shifted;

  always_comb begin
    sel_kind = kinds[ld_idx];
    sel_cov  = ld_cov[ld_idx];
    ld_viol  = ld_valid && ld_any && (sel_kind == K_ARM);
    ld_fwd   = ld_valid && ld_any && (sel_kind == K_REG) && sel_cov;
    ld_stall = ld_valid && ld_any && !ld_viol && !ld_fwd;
    ld_viol_idx  = ld_viol ? ld_idx : '0;
    ld_viol_line = ld_viol ? addrs[ld_idx][AW-1:LINE_LSB] : '0;

    shifted = datas[ld_idx] >> {ld_off[ld_idx], 3'b000};
    for (int b = 0; b < DB; b++) begin
      if (b >= (1 << ld_size)) shifted[8*b +: 8] = 8'h00;
    end
    ld_data = ld_fwd ? shifted : '0;
  end

  // Drain side
  logic head_reg;

  always_comb begin
    head_reg = (kinds[head] == K_REG);
    dc_valid = (count != '0);
    dc_kind  = kinds[head];
    dc_addr  = addrs[head];
    dc_size  = head_reg ? sizes[head] : 2'd0;
    dc_data  = head_reg ? datas[head] : '0;
    rd_en    = dc_valid && dc_ready;
  end

  AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ld_fwd, ld_stall, ld_viol})); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !ld_valid |-> !(ld_fwd || ld_stall || ld_viol)); // R1

  AST_FWD_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_fwd && ld_size == 2'd0) |-> (ld_data[DW-1:8] == '0)); // R4

  AST_TOKEN_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_ni)
    (dc_valid && dc_kind != K_REG) |-> (dc_addr[LINE_LSB-1:0] == '0)); // R2

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (dc_valid && !dc_ready) |=> (dc_valid && $stable(dc_addr) && $stable(dc_kind))); // R2

  AST_STVIOL_DROPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_viol && !rd_en) |=> (count == $past(count))); // R9

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ni)
    (count == CW'(DEPTH) && !rd_en) |=> (count == CW'(DEPTH))); // R3

endmodule

// File: tb/tkq_top_tb.sv
`timescale 1ns/1ps
module tkq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid, enq_ready;
  logic [1:0]  enq_kind;
  logic [31:0] enq_addr;
  logic [1:0]  enq_size;
  logic [63:0] enq_data;
  logic        st_viol;
  logic [2:0]  st_viol_idx;
  logic [25:0] st_viol_line;
  logic        ld_valid;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic        ld_fwd, ld_stall, ld_viol;
  logic [63:0] ld_data;
  logic [2:0]  ld_viol_idx;
  logic [25:0] ld_viol_line;
  logic        dc_valid, dc_ready;
  logic [1:0]  dc_kind;
  logic [31:0] dc_addr;
  logic [1:0]  dc_size;
  logic [63:0] dc_data;

  always #2.5 clk = ~clk;

  tkq_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_kind(enq_kind),
    .enq_addr(enq_addr), .enq_size(enq_size), .enq_data(enq_data),
    .st_viol(st_viol), .st_viol_idx(st_viol_idx), .st_viol_line(st_viol_line),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_fwd(ld_fwd), .ld_data(ld_data), .ld_stall(ld_stall), .ld_viol(ld_viol),
    .ld_viol_idx(ld_viol_idx), .ld_viol_line(ld_viol_line),
    .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_kind(dc_kind),
    .dc_addr(dc_addr), .dc_size(dc_size), .dc_data(dc_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Independent model of queue contents, indexed by slot
  int          m_kind [8];
  longint      m_addr [8];
  int          m_size [8];
  logic [63:0] m_data [8];
  int          m_head = 0;
  int          m_cnt  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_hit(int s, longint lo, longint hi);
    longint el, eh;
    if (m_kind[s] != 0) begin
      el = m_addr[s] >> 6;
      return (el == (lo >> 6)) || (el == ((hi - 1) >> 6));
    end
    el = m_addr[s];
    eh = el + (longint'(1) << m_size[s]);
    return (el < hi) && (lo < eh);
  endfunction

  // Youngest overlapping slot, or -1
  function automatic int m_young(bit tok_only, longint lo, longint hi);
    int r = -1;
    for (int a = 0; a < m_cnt; a++) begin
      int s = (m_head + a) % 8;
      if ((!tok_only || m_kind[s] != 0) && m_hit(s, lo, hi)) r = s;
    end
    return r;
  endfunction

  task automatic enq(input int kind, input longint addr, input int size,
                     input logic [63:0] data);
    longint hi;
    int     y;
    bit     ev, er;
    @(negedge clk);
    enq_valid = 1'b1; enq_kind = 2'(kind); enq_addr = 32'(addr);
    enq_size = 2'(size); enq_data = data;
    #1;
    hi = addr + (longint'(1) << size);
    y  = m_young(1'b1, addr, hi);
    ev = (kind == 0) && (y >= 0) && (m_kind[y] == 1);
    er = (m_cnt < 8);
    chk(enq_ready == er, "R3", "enq_ready", 64'(enq_ready), 64'(er));
    chk(st_viol == ev, (((addr >> 6) != ((hi - 1) >> 6)) ? "R9/R8" : "R9/R10"),
        "st_viol", 64'(st_viol), 64'(ev));
    if (ev) begin
      chk(st_viol_idx == 3'(y), "R9", "st_viol_idx", 64'(st_viol_idx), 64'(y));
      chk(st_viol_line == 26'(m_addr[y] >> 6), "R9", "st_viol_line",
          64'(st_viol_line), 64'(m_addr[y] >> 6));
    end
    @(posedge clk);
    if (er && !ev) begin
      int t = (m_head + m_cnt) % 8;
      m_kind[t] = kind;
      m_addr[t] = (kind != 0) ? (addr & ~longint'(63)) : addr;
      m_size[t] = size;
      m_data[t] = data;
      m_cnt++;
    end
    #1 enq_valid = 1'b0;
  endtask

  task automatic lookup(input longint addr, input int size, input string grp);
    longint      hi;
    int          y;
    bit          ev, es, ef;
    logic [63:0] ed;
    string       lbl;
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 32'(addr); ld_size = 2'(size);
    #1;
    hi = addr + (longint'(1) << size);
    y  = m_young(1'b0, addr, hi);
    ev = 0; es = 0; ef = 0; ed = '0; lbl = "R4";
    if (y >= 0) begin
      if (m_kind[y] == 1) begin
        ev = 1;
        lbl = ((addr >> 6) != ((hi - 1) >> 6)) ? "R8" : "R7";
      end else if (m_kind[y] == 2) begin
        es = 1; lbl = "R6";
      end else if (m_addr[y] <= addr &&
                   hi <= m_addr[y] + (longint'(1) << m_size[y])) begin
        ef = 1;
        ed = m_data[y] >> (8 * (addr - m_addr[y]));
        if (size < 3) ed = ed & ((64'(1) << (8 << size)) - 64'(1));
      end else begin
        es = 1; lbl = "R5";
      end
    end
    chk({ld_viol, ld_stall, ld_fwd} == {ev, es, ef}, {lbl, "/", grp},
        $sformatf("outcome{viol,stall,fwd} @%0h sz%0d", addr, size),
        64'({ld_viol, ld_stall, ld_fwd}), 64'({ev, es, ef}));
    if (ef) chk(ld_data == ed, "R4", $sformatf("ld_data @%0h sz%0d", addr, size),
                ld_data, ed);
    if (ev) begin
      chk(ld_viol_idx == 3'(y), "R7", "ld_viol_idx", 64'(ld_viol_idx), 64'(y));
      chk(ld_viol_line == 26'(m_addr[y] >> 6), "R7", "ld_viol_line",
          64'(ld_viol_line), 64'(m_addr[y] >> 6));
    end
    #1 ld_valid = 1'b0;
  endtask

  task automatic sweep(input longint lo, input longint hi, input string grp);
    for (longint a = lo; a < hi; a++)
      for (int s = 0; s < 4; s++) lookup(a, s, grp);
  endtask

  task automatic drain_one();
    int          h = m_head;
    logic [63:0] ed;
    @(negedge clk);
    dc_ready = 1'b1;
    #1;
    ed = (m_kind[h] == 0) ? m_data[h] : 64'h0;
    chk(dc_valid == 1'b1, "R2", "dc_valid", 64'(dc_valid), 64'd1);
    chk(dc_kind == 2'(m_kind[h]), "R2", "dc_kind", 64'(dc_kind), 64'(m_kind[h]));
    chk(dc_addr == 32'(m_addr[h]), "R2", "dc_addr", 64'(dc_addr), 64'(m_addr[h]));
    chk(dc_size == 2'((m_kind[h] == 0) ? m_size[h] : 0), "R2", "dc_size",
        64'(dc_size), 64'((m_kind[h] == 0) ? m_size[h] : 0));
    chk(dc_data == ed, "R2", "dc_data", dc_data, ed);
    @(posedge clk);
    m_head = (m_head + 1) % 8;
    m_cnt--;
    #1 dc_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enq_valid = 1'b0; enq_kind = '0; enq_addr = '0;
    enq_size = '0; enq_data = '0; ld_valid = 1'b0; ld_addr = '0;
    ld_size = '0; dc_ready = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(dc_valid == 1'b0, "R1", "dc_valid", 64'(dc_valid), 64'd0);
    chk(enq_ready == 1'b1, "R1", "enq_ready", 64'(enq_ready), 64'd1);
    chk({ld_fwd, ld_stall, ld_viol, st_viol} == 4'b0, "R1", "idle outcomes",
        64'({ld_fwd, ld_stall, ld_viol, st_viol}), 64'd0);

    // R4/R5: regular stores, byte sweep
    enq(0, 64'h100, 3, 64'h8786_8584_8382_8180);
    enq(0, 64'h104, 1, 64'h0000_0000_0000_BEEF);
    enq(0, 64'h10A, 2, 64'h0000_0000_C3C2_C1C0);
    sweep(64'hF8, 64'h118, "R4R5");
    repeat (3) drain_one();  // R2

    // R7/R8/R9: arm on line 0x200
    enq(1, 64'h213, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    enq(0, 64'h1F0, 3, 64'h1122_3344_5566_7788);
    enq(0, 64'h23E, 2, 64'h0);             // spans into 0x240: violation
    enq(0, 64'h1FC, 3, 64'h0);             // spans from 0x1C0 line: violation
    enq(0, 64'h220, 0, 64'h0);             // inside armed line
    enq(0, 64'h240, 3, 64'hA5A5_0000_0000_5A5A);
    sweep(64'h1E8, 64'h248, "R7R8");

    // R6/R10: disarm the same line
    enq(2, 64'h220, 0, 64'h0);
    sweep(64'h1F8, 64'h248, "R10");
    enq(0, 64'h208, 3, 64'h0F0E_0D0C_0B0A_0908);  // now legal (R10)
    sweep(64'h200, 64'h214, "R6R10");

    // R3: fill to capacity
    enq(0, 64'h300, 3, 64'h1);
    enq(0, 64'h308, 3, 64'h2);
    enq(0, 64'h310, 3, 64'h3);
    enq(0, 64'h318, 3, 64'h4);   // refused: full
    @(negedge clk);
    chk(enq_ready == 1'b0, "R3", "enq_ready when full", 64'(enq_ready), 64'd0);
    lookup(64'h318, 3, "R3");    // refused entry must not be found

    // R2: drain everything in order, slots wrap
    while (m_cnt > 0) drain_one();
    @(negedge clk);
    chk(dc_valid == 1'b0, "R2", "dc_valid empty", 64'(dc_valid), 64'd0);
    chk(enq_ready == 1'b1, "R3", "enq_ready after drain", 64'(enq_ready), 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule